// File: doc/BRIEF.md
# Stall-Time Memory and Register Snapshot Reader

This block takes a snapshot of a stalled target and streams it out bit by bit. The target consists of a set of ordinary registers, presented to the block as one flat vector, and a single-read-port memory that the block holds. A snapshot request stalls the target. One cycle later the block copies the register vector into a shift chain and sends it out serially over a valid/ready link.

After the register chain, the block dumps the whole memory. It does not add a port and does not build a wide parallel chain. An internal address generator takes over the memory's only read port while the target is stalled. For each address, the block reads one word, loads it into a word-wide scan register and shifts it out. Only after the last bit of that word has been accepted does it move to the next address. Writes from the target are gated off for the whole scan.

After the last memory word the block drops the stall and raises a done flag. Normal target access then resumes. A new request clears the done flag and starts another snapshot.

Top module: `snap_dump`

## Requirements
- R1: While reset is applied, and directly after it is released, `tgtStall`, `soutValid` and `scanDone` are all 0.
- R2: While not stalled, a write through `tgtWrEn`/`tgtWrAddr`/`tgtWrData` updates the memory. The word at `tgtRdAddr` appears on `tgtRdData` one clock edge after the address is presented.
- R3: A `snapReq` seen at a clock edge while idle or done makes `tgtStall` high after that edge. The register vector `tgtRegs` is sampled at the end of the first stalled cycle: the value it holds in that cycle is the value captured, and values before or after it are not.
- R4: The serial stream is ordered as follows. First come all NUM_REGS*REG_W bits of the captured `tgtRegs`, starting at bit 0. Then come the memory words for addresses 0, 1, …, DEPTH-1, each word starting at its bit 0.
- R5: The stream moves forward by one bit only on a cycle where `soutValid` and `soutReady` are both 1. While `soutReady` is 0, `soutValid` stays high and `soutBit` keeps its value.
- R6: Each memory word is fetched through the memory's single read port. The address is presented in one cycle and the data is captured in the next. So with `soutReady` held high, exactly two cycles with `soutValid` low separate the last bit of one segment from the first bit of the next.
- R7: While `tgtStall` is high, target writes have no effect on the memory. A write presented in the same cycle as an accepted `snapReq` still takes effect, and the snapshot shows it.
- R8: In the cycle after the last bit of word DEPTH-1 is accepted, `scanDone` is 1 and `tgtStall` is 0. `scanDone` stays 1 until the next `snapReq`, and that request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snapReq | input | 1 | Snapshot request, taken while idle or done |
| tgtRegs | input | NUM_REGS*REG_W | Flat register state of the target |
| tgtStall | output | 1 | High while a snapshot is in progress; the target must hold |
| scanDone | output | 1 | High after a complete dump until the next request |
| tgtWrEn | input | 1 | Target memory write enable |
| tgtWrAddr | input | ADDR_W | Target memory write address |
| tgtWrData | input | DATA_W | Target memory write data |
| tgtRdAddr | input | ADDR_W | Target memory read address (ignored while stalled) |
| tgtRdData | output | DATA_W | Memory read data, one cycle after the address |
| soutBit | output | 1 | Serial snapshot bit |
| soutValid | output | 1 | Serial bit is valid |
| soutReady | input | 1 | Host accepts the serial bit |

## Verification
Two events can land in the same cycle. A target memory write can arrive in the very cycle a snapshot request is taken. The final accepted bit of a segment can also coincide with the step to the next read address. The bench drives a write to one address together with `snapReq` and expects the new value in the dumped image. It drives a second write in the first stalled cycle and expects that one to be lost, which it confirms by reading the address back after the dump. With the host always ready, the bench also records the cycle of each accepted bit. It checks that each segment boundary shows exactly the two read cycles, and it compares every dumped word with its own memory model.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CAPT   = 3'd1,
    S_RSHIFT = 3'd2,
    S_MREAD  = 3'd3,
    S_MLOAD  = 3'd4,
    S_MSHIFT = 3'd5,
    S_DONE   = 3'd6
  } scan_state_t;

  typedef struct packed {
    logic loadRegs;
    logic shiftRegs;
    logic loadMem;
    logic shiftMem;
    logic clrAddr;
    logic incAddr;
    logic selMem;
  } scan_strobe_t;

endpackage

// File: rtl/snap_ram.sv
module snap_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    rdData <= store[rdAddr];
  end

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         snapReq,
  input  logic         soutReady,
  input  logic         lastBit,
  input  logic         lastAddr,
  output scan_strobe_t strb,
  output logic         tgtStall,
  output logic         scanDone,
  output logic         soutValid
);

  scan_state_t state, stateNext;
  logic accept;

  assign soutValid = (state == S_RSHIFT) || (state == S_MSHIFT);
  assign tgtStall  = (state != S_IDLE) && (state != S_DONE);
  assign scanDone  = (state == S_DONE);
  assign accept    = soutValid && soutReady;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE, S_DONE: begin
        if (snapReq) stateNext = S_CAPT;
      end
      S_CAPT: begin
        strb.loadRegs = 1'b1;
        strb.clrAddr  = 1'b1;
        stateNext     = S_RSHIFT;
      end
      S_RSHIFT: begin
        strb.shiftRegs = accept;
        if (accept && lastBit) stateNext = S_MREAD;
      end
      S_MREAD: begin
        strb.selMem = 1'b1;
        stateNext   = S_MLOAD;
      end
      S_MLOAD: begin
        strb.selMem  = 1'b1;
        strb.loadMem = 1'b1;
        stateNext    = S_MSHIFT;
      end
      S_MSHIFT: begin
        strb.selMem   = 1'b1;
        strb.shiftMem = accept;
        if (accept && lastBit) begin
          if (lastAddr) begin
            stateNext = S_DONE;
          end else begin
            strb.incAddr = 1'b1;
            stateNext    = S_MREAD;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R3: a request taken while not stalled stalls the target and loads the register chain next cycle
  assert_stall_after_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tgtStall && snapReq) |=> (tgtStall && strb.loadRegs));

  // R6: a captured memory word is offered on the very next cycle
  assert_word_offered_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMem |=> soutValid);

  // R8: the stall only ends by completing the dump
  assert_done_on_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtStall) |-> scanDone);

endmodule

// File: rtl/snap_datapath.sv
module snap_datapath
  import snap_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 8,
  localparam int CHAIN_W = NUM_REGS * REG_W,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int MAX_W   = (CHAIN_W > DATA_W) ? CHAIN_W : DATA_W,
  localparam int CNT_W   = $clog2(MAX_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  scan_strobe_t       strb,
  input  logic [CHAIN_W-1:0] regsIn,
  input  logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  scanAddr,
  output logic               soutBit,
  output logic               lastBit,
  output logic               lastAddr
);

  localparam logic [CNT_W-1:0]  REG_LAST  = CNT_W'(CHAIN_W - 1);
  localparam logic [CNT_W-1:0]  WORD_LAST = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  logic [CHAIN_W-1:0] regChain;
  logic [DATA_W-1:0]  memShift;
  logic [CNT_W-1:0]   bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              regChain <= '0;
    else if (strb.loadRegs) regChain <= regsIn;
    else if (strb.shiftRegs) regChain <= regChain >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              memShift <= '0;
    else if (strb.loadMem)  memShift <= rdData;
    else if (strb.shiftMem) memShift <= memShift >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                bitCnt <= '0;
    else if (strb.loadRegs || strb.loadMem)   bitCnt <= '0;
    else if (strb.shiftRegs || strb.shiftMem) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             scanAddr <= '0;
    else if (strb.clrAddr) scanAddr <= '0;
    else if (strb.incAddr) scanAddr <= scanAddr + 1'b1;
  end

  assign soutBit  = strb.selMem ? memShift[0] : regChain[0];
  assign lastBit  = (bitCnt == (strb.selMem ? WORD_LAST : REG_LAST));
  assign lastAddr = (scanAddr == ADDR_LAST);

  // R4: the address walk only steps forward after a full word has been sent
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.incAddr |-> (strb.shiftMem && bitCnt == WORD_LAST));

endmodule

// File: rtl/snap_dump.sv
module snap_dump
  import snap_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 8,
  localparam int CHAIN_W = NUM_REGS * REG_W,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               snapReq,
  input  logic [CHAIN_W-1:0] tgtRegs,
  output logic               tgtStall,
  output logic               scanDone,
  input  logic               tgtWrEn,
  input  logic [ADDR_W-1:0]  tgtWrAddr,
  input  logic [DATA_W-1:0]  tgtWrData,
  input  logic [ADDR_W-1:0]  tgtRdAddr,
  output logic [DATA_W-1:0]  tgtRdData,
  output logic               soutBit,
  output logic               soutValid,
  input  logic               soutReady
);

  scan_strobe_t      strb;
  logic              lastBit, lastAddr;
  logic [ADDR_W-1:0] scanAddr, ramRdAddr;
  logic              ramWrEn;

  assign ramRdAddr = tgtStall ? scanAddr : tgtRdAddr;
  assign ramWrEn   = tgtWrEn && !tgtStall;

  snap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .snapReq   (snapReq),
    .soutReady (soutReady),
    .lastBit   (lastBit),
    .lastAddr  (lastAddr),
    .strb      (strb),
    .tgtStall  (tgtStall),
    .scanDone  (scanDone),
    .soutValid (soutValid)
  );

  snap_datapath #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regsIn   (tgtRegs),
    .rdData   (tgtRdData),
    .scanAddr (scanAddr),
    .soutBit  (soutBit),
    .lastBit  (lastBit),
    .lastAddr (lastAddr)
  );

  snap_ram #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk    (clk),
    .wrEn   (ramWrEn),
    .wrAddr (tgtWrAddr),
    .wrData (tgtWrData),
    .rdAddr (ramRdAddr),
    .rdData (tgtRdData)
  );

  // R5: a refused beat holds both the valid and the offered bit
  assert_hold_on_backpressure_R5: assert property (@(posedge clk) disable iff (!rstN)
    (soutValid && !soutReady) |=> (soutValid && $stable(soutBit)));

  // R1: nothing is offered on the serial link unless the target is held
  assert_valid_needs_stall_R1: assert property (@(posedge clk) disable iff (!rstN)
    soutValid |-> tgtStall);

endmodule

// File: tb/sim_snap_dump.sv
module sim_snap_dump;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 4;
  localparam int REG_W      = 8;
  localparam int DEPTH      = 16;
  localparam int DATA_W     = 8;
  localparam int CHAIN_W    = NUM_REGS * REG_W;
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int TOTAL      = CHAIN_W + DEPTH * DATA_W;

  // table of {address, data} written in normal mode and read back
  localparam logic [15:0] VEC [8] = '{
    16'h00_3C, 16'h0F_A5, 16'h07_81, 16'h01_FF,
    16'h0A_00, 16'h04_5E, 16'h0C_12, 16'h03_E7
  };

  logic               clk = 1'b0;
  logic               rstN;
  logic               snapReq;
  logic [CHAIN_W-1:0] tgtRegs;
  logic               tgtStall, scanDone;
  logic               tgtWrEn;
  logic [ADDR_W-1:0]  tgtWrAddr, tgtRdAddr;
  logic [DATA_W-1:0]  tgtWrData, tgtRdData;
  logic               soutBit, soutValid, soutReady;

  int checks = 0;
  int fails  = 0;

  logic [DATA_W-1:0] model [DEPTH];
  logic              bits  [TOTAL];
  int                when  [TOTAL];

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_dump #(
    .NUM_REGS (NUM_REGS), .REG_W (REG_W), .DEPTH (DEPTH), .DATA_W (DATA_W)
  ) u0 (
    .clk (clk), .rstN (rstN), .snapReq (snapReq), .tgtRegs (tgtRegs),
    .tgtStall (tgtStall), .scanDone (scanDone),
    .tgtWrEn (tgtWrEn), .tgtWrAddr (tgtWrAddr), .tgtWrData (tgtWrData),
    .tgtRdAddr (tgtRdAddr), .tgtRdData (tgtRdData),
    .soutBit (soutBit), .soutValid (soutValid), .soutReady (soutReady)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic memWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    tgtWrEn = 1'b1; tgtWrAddr = a; tgtWrData = d;
    @(negedge clk);
    tgtWrEn = 1'b0;
  endtask

  task automatic memRead(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    tgtRdAddr = a;
    @(negedge clk);
    d = tgtRdData;
  endtask

  // mode 0: host always ready; mode 1: ready low every third cycle
  task automatic collect(input int mode, output int got, output int holdErr);
    int  cyc = 0;
    bit  held = 0;
    logic heldBit = 1'b0;
    got = 0; holdErr = 0;
    while (got < TOTAL && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (held && soutValid && soutBit !== heldBit) holdErr++;
      held = 0;
      soutReady = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (soutValid && soutReady) begin
        bits[got] = soutBit;
        when[got] = cyc;
        got++;
      end else if (soutValid) begin
        held = 1; heldBit = soutBit;
      end
    end
  endtask

  task automatic checkImage(input logic [CHAIN_W-1:0] regsExp, input string tag);
    logic [CHAIN_W-1:0] r;
    for (int i = 0; i < CHAIN_W; i++) r[i] = bits[i];
    check(r === regsExp, {tag, " R4 register segment"}, r, regsExp);
    for (int a = 0; a < DEPTH; a++) begin
      logic [DATA_W-1:0] w;
      for (int b = 0; b < DATA_W; b++) w[b] = bits[CHAIN_W + a*DATA_W + b];
      check(w === model[a], {tag, " R4 memory word"}, w, model[a]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R8 watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int got, holdErr;
    logic [DATA_W-1:0] rd;
    rstN = 1'b0; snapReq = 1'b0; tgtRegs = '0; tgtWrEn = 1'b0;
    tgtWrAddr = '0; tgtWrData = '0; tgtRdAddr = '0; soutReady = 1'b0;
    repeat (3) @(negedge clk);
    check({tgtStall, soutValid, scanDone} == 3'b000, "R1 in reset", {tgtStall, soutValid, scanDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({tgtStall, soutValid, scanDone} == 3'b000, "R1 after reset", {tgtStall, soutValid, scanDone}, 0);

    // fill memory, then overwrite from the table and read back (R2)
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = DATA_W'(a * 29 + 7);
      memWrite(ADDR_W'(a), model[a]);
    end
    for (int i = 0; i < 8; i++) begin
      model[VEC[i][8 +: ADDR_W]] = VEC[i][7:0];
      memWrite(VEC[i][8 +: ADDR_W], VEC[i][7:0]);
    end
    for (int i = 0; i < 8; i++) begin
      memRead(VEC[i][8 +: ADDR_W], rd);
      check(rd === VEC[i][7:0], "R2 table read", rd, VEC[i][7:0]);
    end

    // snapshot 1: write together with request, write while stalled, register timing
    snapReq = 1'b1; tgtRegs = 32'hC0C0_C0C0;
    tgtWrEn = 1'b1; tgtWrAddr = 4'd5; tgtWrData = 8'hC3; model[5] = 8'hC3;
    @(negedge clk);
    snapReq = 1'b0;
    check(tgtStall === 1'b1, "R3 stall after request", tgtStall, 1);
    tgtRegs = 32'h1234_ABCD;
    tgtWrAddr = 4'd6; tgtWrData = 8'hEE;   // blocked: stalled (R7)
    @(negedge clk);
    tgtWrEn = 1'b0;
    tgtRegs = 32'hDEAD_BEEF;
    collect(0, got, holdErr);
    check(got == TOTAL, "R4 bit count", got, TOTAL);
    checkImage(32'h1234_ABCD, "R3 R7 snap1");
    check(when[CHAIN_W] - when[CHAIN_W-1] == 3, "R6 gap regs to word0",
          when[CHAIN_W] - when[CHAIN_W-1], 3);
    check(when[CHAIN_W+DATA_W] - when[CHAIN_W+DATA_W-1] == 3, "R6 gap word0 to word1",
          when[CHAIN_W+DATA_W] - when[CHAIN_W+DATA_W-1], 3);
    @(negedge clk);
    check(scanDone === 1'b1, "R8 done raised", scanDone, 1);
    check(tgtStall === 1'b0, "R8 stall released", tgtStall, 0);
    soutReady = 1'b0;
    repeat (2) @(negedge clk);
    check(scanDone === 1'b1, "R8 done held", scanDone, 1);
    memRead(4'd6, rd);
    check(rd === model[6], "R7 stalled write blocked", rd, model[6]);

    // snapshot 2: backpressure from the host
    snapReq = 1'b1; tgtRegs = 32'h0F1E_2D3C;
    @(negedge clk);
    snapReq = 1'b0;
    check(scanDone === 1'b0, "R8 done cleared by request", scanDone, 0);
    collect(1, got, holdErr);
    check(got == TOTAL, "R5 bit count under backpressure", got, TOTAL);
    check(holdErr == 0, "R5 bit held while not ready", holdErr, 0);
    checkImage(32'h0F1E_2D3C, "R5 snap2");
    @(negedge clk);
    check(scanDone === 1'b1 && tgtStall === 1'b0, "R8 done after snap2", {scanDone, tgtStall}, 2'b10);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule